// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block keeps the 13-bit instruction address of a small processor core and a return-address stack with eight entries. On each clock the core's decoder may ask for one of several actions. It can advance the address by one, or load the low byte as a data write. It can take an absolute jump or a subroutine call with an 11-bit literal, return from a subroutine, or enter the interrupt handler. The block picks the next address and keeps the return stack in step with that choice.

The upper address bits are never written directly. They come from a page-holding value that the core keeps elsewhere and presents on an input. A low-byte write takes all five of its low bits as the upper address. A jump or call takes only its two bits 4:3 as address bits 12:11, and the literal supplies bits 10:0. The return stack is a ring with no visible pointer and no overflow or underflow report. Pushing past eight entries overwrites the oldest ones. Popping an empty stack yields whatever entry the wrapped pointer selects.

Each cycle the block selects one operation: hold, increment, low-byte load, jump, call, return or interrupt vector. A fixed priority does the selection, and a unique case then produces the next address and the stack strobes. The address register and the stack pointer are the only state.

Top module: `pc_retstack_top`

## Requirements
- R1: While reset is low, the address resets to 0000h, the stack pointer resets to slot 0 and every stack entry resets to 0000h. A return issued as the first action after reset therefore yields 0000h.
- R2: An increment request with no higher-priority request makes the next address (pc + 1) modulo 8192, so 1FFFh is followed by 0000h.
- R3: A low-byte write with no higher-priority request loads the address with {page[4:0], write data[7:0]}.
- R4: A jump (jump request with call flag low) loads {page[4:3], literal[10:0]} and leaves the stack unchanged.
- R5: A call (jump request with call flag high) loads the same target as R4 and pushes the present address, which already points at the instruction after the call.
- R6: A return request loads the address from the most recent stack entry that has not yet been popped, in last-in first-out order.
- R7: The stack is a ring of eight slots. A ninth push overwrites the first, and a tenth push overwrites the second. After ten pushes p1..p10, ten pops return p10, p9, ..., p3, then p10, p9.
- R8: An interrupt request loads 0004h and pushes the present address.
- R9: When several requests arrive in the same cycle, only the highest takes effect. The order from highest is interrupt, return, jump/call, low-byte write, increment. With no request the address holds.
- R10: The readable low byte always equals address bits 7:0. The fetch address output equals the low PMEM_AW address bits, so any address above the implemented memory wraps onto it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_req | input | 1 | Advance address by one |
| lowb_we | input | 1 | Write the low address byte |
| lowb_wdata | input | 8 | Data for the low-byte write |
| page_hold | input | 5 | Page-holding value supplying upper address bits |
| jump_req | input | 1 | Jump or call request |
| jump_is_call | input | 1 | With jump_req, push the return address |
| jump_lit | input | 11 | Literal target bits 10:0 |
| ret_req | input | 1 | Pop the stack into the address |
| irq_req | input | 1 | Vector to 0004h and push the address |
| pc | output | 13 | Current instruction address |
| lowb_rdata | output | 8 | Readable low address byte |
| fetch_addr | output | 11 | Address into implemented program memory |

## Verification
The bench sweeps every page-holding value against several byte and literal patterns. A design that mixed up the two ways of building the upper bits would put bits 2:0 into a jump target, or drop them from a byte write. It also walks the increment across 1FFFh, where a counter one bit too wide would not return to zero. Ten calls followed by ten returns test the ring. A stack that saturated, or that flagged overflow instead of wrapping, would return the wrong sequence after the eighth pop. A return straight after reset, and simultaneous requests in every priority pairing, catch a reversed priority or a pointer that starts in the wrong slot.

// File: rtl/pc_retstack_pkg.sv
package pc_retstack_pkg;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_INC   = 3'd1,
        OP_LOWB  = 3'd2,
        OP_JUMP  = 3'd3,
        OP_CALL  = 3'd4,
        OP_RET   = 3'd5,
        OP_IRQ   = 3'd6
    } pcs_op_e;

endpackage

// File: rtl/pcs_op_sel.sv
module pcs_op_sel
    import pc_retstack_pkg::*;
(
    input  logic    irq_req,
    input  logic    ret_req,
    input  logic    jump_req,
    input  logic    jump_is_call,
    input  logic    lowb_we,
    input  logic    inc_req,
    output pcs_op_e op
);

    // fixed priority: interrupt, return, jump/call, byte write, increment
    always_comb begin
        if (irq_req)
            op = OP_IRQ;
        else if (ret_req)
            op = OP_RET;
        else if (jump_req)
            op = jump_is_call ? OP_CALL : OP_JUMP;
        else if (lowb_we)
            op = OP_LOWB;
        else if (inc_req)
            op = OP_INC;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
    import pc_retstack_pkg::*;
#(
    parameter int PC_W   = 13,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 5,
    parameter int LIT_W  = 11,
    parameter logic [PC_W-1:0] IRQ_VEC = 13'h0004
) (
    input  pcs_op_e           op,
    input  logic [PC_W-1:0]   pc_q,
    input  logic [DATA_W-1:0] lowb_wdata,
    input  logic [PAGE_W-1:0] page_hold,
    input  logic [LIT_W-1:0]  jump_lit,
    input  logic [PC_W-1:0]   stack_top,
    output logic [PC_W-1:0]   pc_d,
    output logic              push,
    output logic              pop
);

    localparam int HI_W  = PC_W - DATA_W;   // bits taken from page on byte write
    localparam int SEL_W = PC_W - LIT_W;    // bits taken from page on jump/call
    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] byte_target;
    logic [PC_W-1:0] jump_target;

    assign byte_target = {page_hold[HI_W-1:0], lowb_wdata};
    assign jump_target = {page_hold[PAGE_W-1 -: SEL_W], jump_lit};

    always_comb begin
        pc_d = pc_q;
        push = 1'b0;
        pop  = 1'b0;
        unique case (op)
            OP_HOLD: pc_d = pc_q;
            OP_INC:  pc_d = pc_q + PC_ONE;
            OP_LOWB: pc_d = byte_target;
            OP_JUMP: pc_d = jump_target;
            OP_CALL: begin
                pc_d = jump_target;
                push = 1'b1;
            end
            OP_RET: begin
                pc_d = stack_top;
                pop  = 1'b1;
            end
            OP_IRQ: begin
                pc_d = IRQ_VEC;
                push = 1'b1;
            end
            default: pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [W-1:0]     slot [DEPTH];

    // pointer names the next free slot; it wraps with no flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (push)
            wr_ptr <= wr_ptr + PTR_ONE;
        else if (pop)
            wr_ptr <= rd_ptr;
    end

    assign rd_ptr   = wr_ptr - PTR_ONE;
    assign top_data = slot[rd_ptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (push && (wr_ptr == PTR_W'(i)))
                slot[i] <= push_data;
        end
    end

endmodule

// File: rtl/pc_retstack_top.sv
module pc_retstack_top
    import pc_retstack_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 5,
    parameter int LIT_W     = 11,
    parameter int DEPTH     = 8,
    parameter int PMEM_AW   = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc_req,
    input  logic               lowb_we,
    input  logic [DATA_W-1:0]  lowb_wdata,
    input  logic [PAGE_W-1:0]  page_hold,
    input  logic               jump_req,
    input  logic               jump_is_call,
    input  logic [LIT_W-1:0]   jump_lit,
    input  logic               ret_req,
    input  logic               irq_req,
    output logic [PC_W-1:0]    pc,
    output logic [DATA_W-1:0]  lowb_rdata,
    output logic [PMEM_AW-1:0] fetch_addr
);

    pcs_op_e         op;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] stack_top;
    logic            push;
    logic            pop;

    pcs_op_sel u_sel (
        .irq_req      (irq_req),
        .ret_req      (ret_req),
        .jump_req     (jump_req),
        .jump_is_call (jump_is_call),
        .lowb_we      (lowb_we),
        .inc_req      (inc_req),
        .op           (op)
    );

    pcs_next_pc #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W),
        .LIT_W  (LIT_W)
    ) u_next (
        .op         (op),
        .pc_q       (pc_q),
        .lowb_wdata (lowb_wdata),
        .page_hold  (page_hold),
        .jump_lit   (jump_lit),
        .stack_top  (stack_top),
        .pc_d       (pc_d),
        .push       (push),
        .pop        (pop)
    );

    pcs_ret_stack #(
        .DEPTH (DEPTH),
        .W     (PC_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (pc_q),
        .top_data  (stack_top)
    );

    // address register; reset goes to the reset vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= pc_d;
    end

    assign pc         = pc_q;
    assign lowb_rdata = pc_q[DATA_W-1:0];
    assign fetch_addr = pc_q[PMEM_AW-1:0];

endmodule

// File: rtl/pc_retstack_chk.sv
module pc_retstack_chk #(
    parameter int PC_W    = 13,
    parameter int DATA_W  = 8,
    parameter int PAGE_W  = 5,
    parameter int LIT_W   = 11,
    parameter int PMEM_AW = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inc_req,
    input logic               lowb_we,
    input logic [DATA_W-1:0]  lowb_wdata,
    input logic [PAGE_W-1:0]  page_hold,
    input logic               jump_req,
    input logic [LIT_W-1:0]   jump_lit,
    input logic               ret_req,
    input logic               irq_req,
    input logic [PC_W-1:0]    pc,
    input logic [DATA_W-1:0]  lowb_rdata
);

    localparam int SEL_W = PC_W - LIT_W;
    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    p_reset_vec_r1: assert property (@(posedge clk)
        !rst_n |=> pc == '0);

    p_inc_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc_req && !lowb_we && !jump_req && !ret_req && !irq_req
        |=> pc == $past(pc) + PC_ONE);

    p_byte_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lowb_we && !jump_req && !ret_req && !irq_req
        |=> pc == {$past(page_hold[PC_W-DATA_W-1:0]), $past(lowb_wdata)});

    p_jump_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req && !ret_req && !irq_req
        |=> pc == {$past(page_hold[PAGE_W-1 -: SEL_W]), $past(jump_lit)});

    p_irq_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> pc == 13'h0004);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_req && !lowb_we && !jump_req && !ret_req && !irq_req
        |=> $stable(pc));

    // R10: low byte output tracks the address register
    always_comb begin
        if (rst_n)
            a_lowbyte_r10: assert (lowb_rdata == pc[DATA_W-1:0]);
    end

endmodule

bind pc_retstack_top pc_retstack_chk #(
    .PC_W    (PC_W),
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W),
    .LIT_W   (LIT_W),
    .PMEM_AW (PMEM_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_req    (inc_req),
    .lowb_we    (lowb_we),
    .lowb_wdata (lowb_wdata),
    .page_hold  (page_hold),
    .jump_req   (jump_req),
    .jump_lit   (jump_lit),
    .ret_req    (ret_req),
    .irq_req    (irq_req),
    .pc         (pc),
    .lowb_rdata (lowb_rdata)
);

// File: tb/pc_retstack_top_bench.sv
module pc_retstack_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_req = 1'b0;
    logic        lowb_we = 1'b0;
    logic [7:0]  lowb_wdata = '0;
    logic [4:0]  page_hold = '0;
    logic        jump_req = 1'b0;
    logic        jump_is_call = 1'b0;
    logic [10:0] jump_lit = '0;
    logic        ret_req = 1'b0;
    logic        irq_req = 1'b0;
    logic [12:0] pc;
    logic [7:0]  lowb_rdata;
    logic [10:0] fetch_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [12:0] exp_pc;
    logic [12:0] mstk [8];
    int          mptr;

    always #5 clk = ~clk;

    pc_retstack_top u_pc_retstack_top (
        .clk (clk), .rst_n (rst_n), .inc_req (inc_req), .lowb_we (lowb_we),
        .lowb_wdata (lowb_wdata), .page_hold (page_hold), .jump_req (jump_req),
        .jump_is_call (jump_is_call), .jump_lit (jump_lit), .ret_req (ret_req),
        .irq_req (irq_req), .pc (pc), .lowb_rdata (lowb_rdata),
        .fetch_addr (fetch_addr)
    );

    task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_pc(input string tag);
        chk(tag, pc, exp_pc);
        chk("R10 lowbyte", {5'd0, lowb_rdata}, {5'd0, exp_pc[7:0]});
        chk("R10 fetch", {2'd0, fetch_addr}, {2'd0, exp_pc[10:0]});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_pc = '0;
        mptr = 0;
        for (int i = 0; i < 8; i++) mstk[i] = '0;
    endtask

    // one cycle of requests; reference model follows the requirement text
    task automatic step(input bit irq, input bit ret, input bit jmp, input bit call,
                        input bit bwr, input bit inc, input logic [7:0] data,
                        input logic [4:0] page, input logic [10:0] lit);
        irq_req = irq; ret_req = ret; jump_req = jmp; jump_is_call = call;
        lowb_we = bwr; inc_req = inc; lowb_wdata = data; page_hold = page;
        jump_lit = lit;
        if (irq) begin
            mstk[mptr] = exp_pc; mptr = (mptr + 1) % 8; exp_pc = 13'h0004;
        end else if (ret) begin
            mptr = (mptr + 7) % 8; exp_pc = mstk[mptr];
        end else if (jmp) begin
            if (call) begin mstk[mptr] = exp_pc; mptr = (mptr + 1) % 8; end
            exp_pc = {page[4:3], lit};
        end else if (bwr) begin
            exp_pc = {page, data};
        end else if (inc) begin
            exp_pc = (exp_pc + 13'd1) & 13'h1FFF;
        end
        @(negedge clk);
        irq_req = 0; ret_req = 0; jump_req = 0; jump_is_call = 0;
        lowb_we = 0; inc_req = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected below 100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  pats [4];
        logic [10:0] lits [4];
        logic [12:0] pushed [10];
        pats[0] = 8'h00; pats[1] = 8'h5A; pats[2] = 8'hA5; pats[3] = 8'hFF;
        lits[0] = 11'h000; lits[1] = 11'h7FF; lits[2] = 11'h2AA; lits[3] = 11'h555;

        // R1: reset state
        do_reset();
        check_pc("R1 reset");
        // R1: pop right after reset yields a reset entry
        step(0, 1, 0, 0, 0, 0, 8'h00, 5'h00, 11'h0);
        check_pc("R1 pop after reset");

        // R2: increment across the top of the address space
        do_reset();
        step(0, 0, 0, 0, 1, 0, 8'hF0, 5'h1F, 11'h0);
        check_pc("R3 preload");
        for (int i = 0; i < 20; i++) begin
            step(0, 0, 0, 0, 0, 1, 8'h00, 5'h00, 11'h0);
            check_pc("R2 increment");
        end
        // R9: no request holds
        step(0, 0, 0, 0, 0, 0, 8'h33, 5'h0A, 11'h123);
        check_pc("R9 hold");

        // R3: byte write sweep over all page values
        for (int p = 0; p < 32; p++)
            for (int d = 0; d < 4; d++) begin
                step(0, 0, 0, 0, 1, 0, pats[d], 5'(p), 11'h0);
                check_pc("R3 byte load");
            end

        // R4: jump sweep; stack must remain untouched (checked via pop below)
        do_reset();
        for (int p = 0; p < 32; p++)
            for (int d = 0; d < 4; d++) begin
                step(0, 0, 1, 0, 0, 0, 8'h00, 5'(p), lits[d]);
                check_pc("R4 jump");
            end
        step(0, 1, 0, 0, 0, 0, 8'h00, 5'h00, 11'h0);
        check_pc("R4 jump left stack alone");

        // R5 R6 R7: ten calls, then ten returns
        do_reset();
        for (int i = 0; i < 10; i++) begin
            step(0, 0, 0, 0, 1, 0, 8'(i * 17 + 3), 5'(i + 4), 11'h0);
            pushed[i] = exp_pc;
            step(0, 0, 1, 1, 0, 0, 8'h00, 5'(i * 3), 11'(i * 97 + 11));
            check_pc("R5 call target");
        end
        for (int i = 0; i < 10; i++) begin
            logic [12:0] want;
            want = (i < 8) ? pushed[9 - i] : pushed[17 - i];
            step(0, 1, 0, 0, 0, 0, 8'h00, 5'h00, 11'h0);
            chk("R7 ring order", pc, want);
            check_pc("R6 return");
        end

        // R8: interrupt vector and return
        do_reset();
        step(0, 0, 0, 0, 1, 0, 8'h77, 5'h12, 11'h0);
        step(1, 0, 0, 0, 0, 0, 8'h00, 5'h00, 11'h0);
        check_pc("R8 vector");
        step(0, 1, 0, 0, 0, 0, 8'h00, 5'h00, 11'h0);
        chk("R8 return addr", pc, 13'h1277);

        // R9: priority pairings
        for (int m = 1; m < 32; m++) begin
            step(0, 0, 0, 0, 1, 0, 8'(m * 5), 5'(m), 11'h0);
            step(m[4], m[3], m[2], m[0], m[1], 1'b1, 8'hC3, 5'(31 - m), 11'(m * 61));
            check_pc("R9 priority");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule